// File: doc/BRIEF.md
# Power-Up and Crystal-Settle Sequencer

This controller takes a radio core through its start-up phases. While the power-on-reset release input is low, it holds the core in a reset-wait phase. Once that input goes high, it enters IDLE. It stays there for a programmable crystal-settle interval, chosen by a 3-bit code. When the interval ends, it fires a one-cycle calibration-start pulse and waits in CALIBRATE for the calibration engine to report completion. It then parks in SLEEP until the host takes over.

A soft-reset strobe sends the controller back to IDLE from any phase and restarts the settle interval. All pins are plain control and status lines: no data stream crosses this block, so there is no valid/ready handshake. The settle code is read only at the moment IDLE is entered. The interval length is built from two parameters: a base time in microseconds and a count of clock cycles per microsecond. The code doubles the base time per step.

Top module: `pwrup_seq`

## Requirements
- R1: While `por_ok` is low, `state` reads 0 (reset-wait) from the next clock edge onward, in any phase; `rst_n` low forces 0 at once. This overrides every other input.
- R2: `state` encoding is 0 reset-wait, 1 IDLE, 2 CALIBRATE, 3 SLEEP. Phases advance only in that order.
- R3: IDLE lasts exactly (BASE_US << code) * CYC_PER_US clock cycles. The defaults are BASE_US=155 and CYC_PER_US=100, so code 4 gives 2.48 ms at 100 MHz.
- R4: `cal_start` is high for exactly one cycle, the first cycle in which `state` reads 2.
- R5: `cal_done` high while in CALIBRATE moves `state` to 3 on the next edge. SLEEP is then held until `soft_rst` or `por_ok` low.
- R6: `soft_rst` high with `por_ok` high moves `state` to 1 on the next edge from any phase, IDLE included. This restarts the full settle interval.
- R7: `settle_code` is sampled only on the edge that enters IDLE. Changes made while in IDLE do not alter the running interval.
- R8: `cal_done` has no effect outside CALIBRATE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_ok | input | 1 | Power-on-reset released (level) |
| settle_code | input | 3 | Crystal-settle interval select |
| cal_done | input | 1 | Calibration complete strobe |
| soft_rst | input | 1 | Soft reset strobe |
| state | output | 2 | Current phase (0..3) |
| cal_start | output | 1 | One-cycle calibration start pulse |

## Verification
The bench sweeps every settle code from shortest to longest. This shows whether the interval doubles per step and is off by no cycle. It also rewrites the code mid-IDLE to show whether the value is latched or read live. Soft resets are issued in each phase, including mid-IDLE, to expose any path that fails to restart the timer. Completion strobes are given outside CALIBRATE, and POR is dropped while a soft reset is held, to separate the intended priorities from plausible wrong ones.

// File: rtl/pwrup_pkg.sv
package pwrup_pkg;
  typedef enum logic [1:0] {
    PS_RSTWAIT = 2'd0,
    PS_IDLE    = 2'd1,
    PS_CAL     = 2'd2,
    PS_SLEEP   = 2'd3
  } pstate_t;

  localparam int unsigned CODE_W = 3;
  localparam int unsigned N_CODES = 1 << CODE_W;
endpackage

// File: rtl/settle_table.sv
module settle_table
  import pwrup_pkg::*;
#(
  parameter int unsigned BASE_US    = 155,
  parameter int unsigned CYC_PER_US = 100,
  parameter int unsigned CW         = 21
) (
  input  logic [CODE_W-1:0] code,
  output logic [CW-1:0]     reload
);
  logic [CW-1:0] tbl [N_CODES];

  // Each code doubles the interval; stored value is cycles minus one.
  for (genvar g = 0; g < N_CODES; g++) begin : g_entry
    localparam int unsigned CYC = (BASE_US * CYC_PER_US) << g;
    assign tbl[g] = CW'(CYC - 1);
  end

  assign reload = tbl[code];
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int unsigned CW = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic          expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (load)             cnt <= load_val;
    else if (dec && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // R3: a running countdown never jumps back up without a reload
  p_monotonic_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && dec) |=> (cnt <= $past(cnt)));
endmodule

// File: rtl/pwrup_fsm.sv
module pwrup_fsm
  import pwrup_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    por_ok,
  input  logic    soft_rst,
  input  logic    cal_done,
  input  logic    expired,
  output pstate_t st,
  output logic    load,
  output logic    dec,
  output logic    cal_start
);
  pstate_t st_nx;

  always_comb begin
    st_nx = st;
    if (!por_ok)       st_nx = PS_RSTWAIT;
    else if (soft_rst) st_nx = PS_IDLE;
    else begin
      unique case (st)
        PS_RSTWAIT: st_nx = PS_IDLE;
        PS_IDLE:    if (expired) st_nx = PS_CAL;
        PS_CAL:     if (cal_done) st_nx = PS_SLEEP;
        PS_SLEEP:   st_nx = PS_SLEEP;
        default:    st_nx = PS_RSTWAIT;
      endcase
    end
  end

  // Reload on every entry to IDLE, including a soft reset taken inside IDLE.
  assign load = (st_nx == PS_IDLE) && ((st != PS_IDLE) || soft_rst);
  assign dec  = (st == PS_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= PS_RSTWAIT;
      cal_start <= 1'b0;
    end else begin
      st        <= st_nx;
      cal_start <= (st == PS_IDLE) && (st_nx == PS_CAL);
    end
  end

  // R1: POR low always lands in reset-wait
  p_por_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !por_ok |=> (st == PS_RSTWAIT));

  // R2: CALIBRATE is entered only from IDLE
  p_cal_from_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st != PS_CAL && st != PS_IDLE) |=> (st != PS_CAL));

  // R4: start pulse lasts one cycle and coincides with CALIBRATE
  p_pulse_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |=> !cal_start);
  p_pulse_state_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |-> (st == PS_CAL));

  // R5: SLEEP persists without a reset source
  p_sleep_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PS_SLEEP && por_ok && !soft_rst) |=> (st == PS_SLEEP));

  // R6: soft reset re-enters IDLE
  p_soft_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (por_ok && soft_rst) |=> (st == PS_IDLE));
endmodule

// File: rtl/pwrup_seq.sv
module pwrup_seq
  import pwrup_pkg::*;
#(
  parameter int unsigned BASE_US    = 155,
  parameter int unsigned CYC_PER_US = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_ok,
  input  logic [2:0] settle_code,
  input  logic       cal_done,
  input  logic       soft_rst,
  output logic [1:0] state,
  output logic       cal_start
);
  localparam int unsigned MAX_CYC = (BASE_US * CYC_PER_US) << (N_CODES - 1);
  localparam int unsigned CW      = $clog2(MAX_CYC);

  logic [CW-1:0] reload;
  logic          load, dec, expired;
  pstate_t       st;

  settle_table #(.BASE_US(BASE_US), .CYC_PER_US(CYC_PER_US), .CW(CW)) u_table (
    .code   (settle_code),
    .reload (reload)
  );

  settle_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (reload),
    .dec      (dec),
    .expired  (expired)
  );

  pwrup_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .por_ok    (por_ok),
    .soft_rst  (soft_rst),
    .cal_done  (cal_done),
    .expired   (expired),
    .st        (st),
    .load      (load),
    .dec       (dec),
    .cal_start (cal_start)
  );

  assign state = st;

  // R8: completion strobe outside CALIBRATE changes nothing in SLEEP/IDLE flow
  p_done_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_done && por_ok && !soft_rst && st == PS_SLEEP) |=> (st == PS_SLEEP));
endmodule

// File: tb/tb_pwrup_seq.sv
module tb_pwrup_seq;
  localparam int unsigned BASE = 3;
  localparam int unsigned CPU  = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       por_ok = 1'b0;
  logic [2:0] settle_code = 3'd0;
  logic       cal_done = 1'b0;
  logic       soft_rst = 1'b0;
  logic [1:0] state;
  logic       cal_start;

  int vectors = 0;
  int misses  = 0;
  int cycles  = 0;
  string req  = "R1";

  // reference model
  int m_state = 0;
  int m_left  = 0;
  int m_pulse = 0;

  always #5 clk = ~clk;

  pwrup_seq #(.BASE_US(BASE), .CYC_PER_US(CPU)) dut (
    .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .settle_code(settle_code),
    .cal_done(cal_done), .soft_rst(soft_rst), .state(state), .cal_start(cal_start)
  );

  function automatic int idle_len(input int code);
    return (BASE << code) * CPU;
  endfunction

  task automatic model_edge();
    int nxt;
    m_pulse = 0;
    if (!rst_n) begin
      m_state = 0;
      return;
    end
    if (!por_ok) nxt = 0;
    else if (soft_rst) begin
      nxt = 1;
      m_left = idle_len(settle_code);
    end else begin
      nxt = m_state;
      case (m_state)
        0: begin nxt = 1; m_left = idle_len(settle_code); end
        1: begin
             m_left--;
             if (m_left == 0) begin nxt = 2; m_pulse = 1; end
           end
        2: if (cal_done) nxt = 3;
        default: nxt = 3;
      endcase
    end
    m_state = nxt;
  endtask

  task automatic compare();
    vectors++;
    if (int'(state) != m_state) begin
      misses++;
      $display("FAIL %s state actual=%0d expected=%0d t=%0t", req, state, m_state, $time);
    end
    vectors++;
    if (int'(cal_start) != m_pulse) begin
      misses++;
      $display("FAIL %s cal_start actual=%0d expected=%0d t=%0t", req, cal_start, m_pulse, $time);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare();
    end
  endtask

  task automatic wait_state(input int s, input int limit);
    for (int i = 0; i < limit && m_state != s; i++) step();
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 60000) begin
        misses++;
        $display("FAIL watchdog actual=%0d expected<=60000 cycles", cycles);
        finish_run();
      end
    end
  end

  initial begin
    // R1: reset state
    req = "R1";
    @(negedge clk);
    compare();
    step(2);
    rst_n = 1'b1;
    step(5);                       // R1: POR low holds reset-wait

    // R2/R3: full walk with the shortest code
    req = "R3";
    settle_code = 3'd0;
    por_ok = 1'b1;
    wait_state(2, 100);
    req = "R4";
    step(3);
    req = "R5";
    cal_done = 1'b1; step(); cal_done = 1'b0;
    step(4);
    // R8: completion strobe in SLEEP ignored
    req = "R8";
    cal_done = 1'b1; step(3); cal_done = 1'b0;
    step(2);

    // R3: sweep every code via soft reset from SLEEP (R6)
    for (int c = 0; c < 8; c++) begin
      req = "R6";
      settle_code = 3'(c);
      soft_rst = 1'b1; step(); soft_rst = 1'b0;
      req = "R8";
      cal_done = 1'b1; step(2); cal_done = 1'b0;  // ignored in IDLE
      req = "R3";
      wait_state(2, 1000);
      step(2);
      req = "R5";
      cal_done = 1'b1; step(); cal_done = 1'b0;
      step(2);
    end

    // R7: code change mid-IDLE has no effect on the running interval
    req = "R7";
    settle_code = 3'd2;
    soft_rst = 1'b1; step(); soft_rst = 1'b0;
    step(3);
    settle_code = 3'd7;
    wait_state(2, 1000);
    step(2);

    // R6: soft reset mid-IDLE restarts the interval; soft reset in CALIBRATE
    req = "R6";
    settle_code = 3'd1;
    soft_rst = 1'b1; step(); soft_rst = 1'b0;
    step(5);
    soft_rst = 1'b1; step(); soft_rst = 1'b0;
    wait_state(2, 100);
    step(1);
    soft_rst = 1'b1; step(); soft_rst = 1'b0;
    wait_state(2, 100);
    cal_done = 1'b1; step(); cal_done = 1'b0;

    // R1: POR low overrides soft reset, from SLEEP
    req = "R1";
    por_ok = 1'b0; soft_rst = 1'b1; step(3); soft_rst = 1'b0;
    step(2);
    por_ok = 1'b1;
    req = "R2";
    wait_state(2, 100);
    step(2);
    // R1: POR drop in CALIBRATE
    req = "R1";
    por_ok = 1'b0; step(2);
    // R1: async reset mid-IDLE
    por_ok = 1'b1; step(4);
    rst_n = 1'b0; step(2); rst_n = 1'b1;
    step(3);

    finish_run();
  end
endmodule